// File: doc/BRIEF.md
# Dual Down-Counter Timer

This peripheral holds two independent down-counting timer channels behind an APB slave port. Software programs each channel with a start count, a divider for the input clock and a counting mode. The channel then decrements once per divided tick and raises an interrupt when the count reaches zero. What happens after zero depends on the mode. A free-running channel wraps to the all-ones value of its width. A periodic channel restarts from its reload value. A one-shot channel stops at zero.

Each channel drives its own interrupt line, gated by that channel's interrupt enable. A combined line is asserted while either channel interrupt is active. A second reload register lets software change the next period without disturbing the count in progress. The counter runs either as a 16-bit or as a 32-bit counter.

Top module: `dual_countdown_timer`

## Requirements
- R1: Each channel occupies 32 bytes, and channel n starts at byte offset 0x20*n. Within a channel the registers sit at these offsets: 0x00 start count, 0x04 current count, 0x08 control, 0x0C interrupt clear, 0x10 raw flag, 0x14 gated flag, 0x18 reload-only. The control fields are: bit 7 run, bit 6 periodic, bit 5 interrupt enable, bits 3:2 divider, bit 1 32-bit width, bit 0 one-shot. Control bit 4 and bits 31:8 read as 0.
- R2: After reset, in both channels, control reads 0, start count reads 0, the raw flag reads 0 and the current count reads 0x0000FFFF (the stored all-ones value seen through the 16-bit width). Both interrupt outputs are low.
- R3: Divider code 0 gives one tick per clock, code 1 gives one tick every 16 clocks, and code 2 gives one tick every 256 clocks. The first tick comes that many clocks after the write that enables the channel or loads its count.
- R4: A write to the start count sets both the current count and the reload value, and restarts the divider phase. While the channel is enabled the count then drops by one per tick.
- R5: When a tick brings the count from 1 to 0, the raw flag becomes 1 at that same clock edge.
- R6: In free-running mode (periodic = 0 and one-shot = 0), the tick after zero loads the all-ones value of the selected width: 0xFFFF or 0xFFFFFFFF.
- R7: In periodic mode, the tick after zero reloads the count from the reload value.
- R8: In one-shot mode the count stays at zero until a new start count is written. The one-shot bit takes priority over the periodic bit.
- R9: A write to the reload-only register changes the value used at the next reload and the value read back at offset 0x00. It does not change the current count.
- R10: A write of any data to the interrupt clear register clears the raw flag. If a tick reaches zero in the same cycle, the set wins.
- R11: The gated flag and the channel interrupt output both equal the raw flag AND the interrupt enable. The combined interrupt is high whenever any channel interrupt is high.
- R12: In 16-bit mode only bits 15:0 count, and the current count reads 0 in bits 31:16. In 32-bit mode the borrow propagates across all 32 bits.
- R13: With the run bit clear, the current count holds its value.
- R14: Accesses to one channel do not change the count of the other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W (6) | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid while psel is high and pwrite is low |
| irq | output | NUM_CH (2) | Per-channel interrupt |
| irq_any | output | 1 | OR of all channel interrupts |

## Verification
A wrong divider phase or an off-by-one in the decrement shows up at once as a count read one tick away from the expected value. The bench therefore reads counts exactly one clock before and one clock after a divided tick. A wrongly chosen mode after zero appears within a single tick as a count of 0xFFFF, the reload value or 0. A raw flag that is set early, late or not cleared appears on the interrupt output in the same cycle as the flag. A reload-only write that disturbs the count is visible on the very next count read, several ticks before the reload takes effect.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int DATA_W    = 32;
    localparam int PRESC_W   = 8;
    localparam int SEL_LSB   = 2;
    localparam int SEL_W     = 3;
    localparam int CH_LSB    = SEL_LSB + SEL_W;

    typedef enum logic [SEL_W-1:0] {
        SEL_START   = 3'd0,
        SEL_COUNT   = 3'd1,
        SEL_CTRL    = 3'd2,
        SEL_CLEAR   = 3'd3,
        SEL_RAW     = 3'd4,
        SEL_GATED   = 3'd5,
        SEL_RELOAD  = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic       run;
        logic       periodic;
        logic       int_en;
        logic [1:0] divider;
        logic       wide;
        logic       oneshot;
    } ctrl_t;

    typedef struct packed {
        logic start;
        logic ctrl;
        logic clear;
        logic reload;
    } chan_wr_t;

    function automatic ctrl_t ctrl_decode(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.run      = w[7];
        c.periodic = w[6];
        c.int_en   = w[5];
        c.divider  = w[3:2];
        c.wide     = w[1];
        c.oneshot  = w[0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_encode(input ctrl_t c);
        return {{(DATA_W-8){1'b0}}, c.run, c.periodic, c.int_en, 1'b0,
                c.divider, c.wide, c.oneshot};
    endfunction

    function automatic logic [PRESC_W-1:0] presc_limit(input logic [1:0] code);
        case (code)
            2'd0:    return PRESC_W'(0);
            2'd1:    return PRESC_W'(15);
            default: return PRESC_W'(255);
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(input logic wide);
        return wide ? {DATA_W{1'b1}} : {{(DATA_W-16){1'b0}}, 16'hFFFF};
    endfunction

endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler
    import dtmr_pkg::*;
#(
    parameter int CNT_W = PRESC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             tick
);

    logic [CNT_W-1:0] phase_q;
    logic             at_limit;

    assign at_limit = (phase_q == limit);
    assign tick     = run && !restart && at_limit;

    always_ff @(posedge clk) begin
        if (rst || !run || restart || at_limit) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
    import dtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  chan_wr_t          wr,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] count_view,
    output logic [DATA_W-1:0] reload_view,
    output logic              raw,
    output logic              gated
);

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] count_n;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] cur;
    logic              raw_q;
    logic              tick;
    logic              hit_zero;

    dtmr_prescaler #(.CNT_W(PRESC_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.run),
        .restart (wr.start),
        .limit   (presc_limit(ctrl_q.divider)),
        .tick    (tick)
    );

    always_comb begin
        mask     = width_mask(ctrl_q.wide);
        cur      = count_q & mask;
        count_n  = count_q;
        hit_zero = 1'b0;
        if (wr.start) begin
            count_n = wdata;
        end else if (tick) begin
            if (cur == '0) begin
                if (ctrl_q.oneshot) begin
                    count_n = cur;
                end else if (ctrl_q.periodic) begin
                    count_n = reload_q;
                end else begin
                    count_n = mask;
                end
            end else begin
                count_n  = cur - 1'b1;
                hit_zero = (cur == DATA_W'(1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            count_q  <= '1;
            reload_q <= '0;
            raw_q    <= 1'b0;
        end else begin
            if (wr.ctrl) begin
                ctrl_q <= ctrl_decode(wdata);
            end
            if (wr.start || wr.reload) begin
                reload_q <= wdata;
            end
            count_q <= count_n;
            if (hit_zero) begin
                raw_q <= 1'b1;
            end else if (wr.clear) begin
                raw_q <= 1'b0;
            end
        end
    end

    assign ctrl        = ctrl_q;
    assign count_view  = count_q & mask;
    assign reload_view = reload_q;
    assign raw         = raw_q;
    assign gated       = raw_q & ctrl_q.int_en;

endmodule

// File: rtl/dtmr_regif.sv
module dtmr_regif
    import dtmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = $clog2(NUM_CH),
    parameter int ADDR_W = CH_LSB + CH_W
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output chan_wr_t          wr        [NUM_CH],
    input  ctrl_t             ch_ctrl   [NUM_CH],
    input  logic [DATA_W-1:0] ch_count  [NUM_CH],
    input  logic [DATA_W-1:0] ch_reload [NUM_CH],
    input  logic [NUM_CH-1:0] ch_raw,
    input  logic [NUM_CH-1:0] ch_gated,
    output logic [DATA_W-1:0] prdata
);

    logic            access_wr;
    logic [CH_W-1:0] ch_idx;
    reg_sel_e        sel;
    logic            unused_addr_lsb;

    assign access_wr       = psel && penable && pwrite;
    assign ch_idx          = paddr[ADDR_W-1:CH_LSB];
    assign sel             = reg_sel_e'(paddr[CH_LSB-1:SEL_LSB]);
    assign unused_addr_lsb = ^paddr[SEL_LSB-1:0];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        logic hit;
        assign hit             = access_wr && (ch_idx == CH_W'(i));
        assign wr[i].start     = hit && (sel == SEL_START);
        assign wr[i].ctrl      = hit && (sel == SEL_CTRL);
        assign wr[i].clear     = hit && (sel == SEL_CLEAR);
        assign wr[i].reload    = hit && (sel == SEL_RELOAD);
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_idx == CH_W'(i)) begin
                    case (sel)
                        SEL_START:  prdata = ch_reload[i];
                        SEL_COUNT:  prdata = ch_count[i];
                        SEL_CTRL:   prdata = ctrl_encode(ch_ctrl[i]);
                        SEL_RAW:    prdata = {{(DATA_W-1){1'b0}}, ch_raw[i]};
                        SEL_GATED:  prdata = {{(DATA_W-1){1'b0}}, ch_gated[i]};
                        SEL_RELOAD: prdata = ch_reload[i];
                        default:    prdata = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
    import dtmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = CH_LSB + $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic [NUM_CH-1:0] irq,
    output logic              irq_any
);

    localparam int CH_W = $clog2(NUM_CH);

    chan_wr_t          ch_wr     [NUM_CH];
    ctrl_t             ch_ctrl   [NUM_CH];
    logic [DATA_W-1:0] ch_count  [NUM_CH];
    logic [DATA_W-1:0] ch_reload [NUM_CH];
    logic [NUM_CH-1:0] ch_raw;
    logic [NUM_CH-1:0] ch_gated;

    dtmr_regif #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_regif (
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .wr        (ch_wr),
        .ch_ctrl   (ch_ctrl),
        .ch_count  (ch_count),
        .ch_reload (ch_reload),
        .ch_raw    (ch_raw),
        .ch_gated  (ch_gated),
        .prdata    (prdata)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dtmr_channel u_chan (
            .clk         (clk),
            .rst         (rst),
            .wr          (ch_wr[i]),
            .wdata       (pwdata),
            .ctrl        (ch_ctrl[i]),
            .count_view  (ch_count[i]),
            .reload_view (ch_reload[i]),
            .raw         (ch_raw[i]),
            .gated       (ch_gated[i])
        );
    end

    assign irq     = ch_gated;
    assign irq_any = |ch_gated;

endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker
    import dtmr_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] irq,
    input chan_wr_t          ch_wr    [NUM_CH],
    input ctrl_t             ch_ctrl  [NUM_CH],
    input logic [DATA_W-1:0] ch_count [NUM_CH],
    input logic [NUM_CH-1:0] ch_raw
);

    a_r2_reset_quiet: assert property (@(posedge clk)
        rst |=> (ch_raw == '0 && irq == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        a_r5_raw_at_zero: assert property (@(posedge clk) disable iff (rst)
            $rose(ch_raw[i]) |-> (ch_count[i] == '0));

        a_r10_clear_drops_raw: assert property (@(posedge clk) disable iff (rst)
            ch_wr[i].clear |=> (!ch_raw[i] || ch_count[i] == '0));

        a_r13_stopped_holds: assert property (@(posedge clk) disable iff (rst)
            (!ch_ctrl[i].run && !ch_wr[i].start && !ch_wr[i].ctrl)
            |=> $stable(ch_count[i]));

        a_r8_oneshot_parks: assert property (@(posedge clk) disable iff (rst)
            (ch_ctrl[i].run && ch_ctrl[i].oneshot && ch_count[i] == '0
             && !ch_wr[i].start && !ch_wr[i].ctrl)
            |=> (ch_count[i] == '0));

        a_r11_irq_gated: assert property (@(posedge clk) disable iff (rst)
            !ch_ctrl[i].int_en |-> !irq[i]);
    end

endmodule

bind dual_countdown_timer dtmr_checker #(.NUM_CH(NUM_CH)) u_dtmr_checker (
    .clk      (clk),
    .rst      (rst),
    .irq      (irq),
    .ch_wr    (ch_wr),
    .ch_ctrl  (ch_ctrl),
    .ch_count (ch_count),
    .ch_raw   (ch_raw)
);

// File: tb/dual_countdown_timer_bench.sv
module dual_countdown_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [5:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [1:0]  irq;
    logic        irq_any;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int t0 = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dual_countdown_timer u_dual_countdown_timer (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq), .irq_any(irq_any)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        psel = 1'b0; penable = 1'b0;
    endtask

    // read so that the sample falls exactly 'target' clocks after t0
    task automatic adv_rd(input logic [5:0] a, input int target, output logic [31:0] d);
        while ((cyc - t0) < target - 2) @(negedge clk);
        rd(a, d);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(6'h10, d); check("R2 ch1 raw", d, 0);
        rd(6'h30, d); check("R2 ch2 raw", d, 0);
        rd(6'h08, d); check("R2 ch1 ctrl", d, 0);
        rd(6'h00, d); check("R2 ch1 start", d, 0);
        rd(6'h24, d); check("R2 ch2 count", d, 32'h0000FFFF);
        check("R2 irq", {29'd0, irq_any, irq}, 0);
        wr(6'h08, 32'h7B);
        rd(6'h08, d); check("R1 ctrl fields, bit4 zero", d, 32'h6B);
        wr(6'h08, 32'h0);
    endtask

    task automatic t_freerun;
        logic [31:0] d, held;
        wr(6'h00, 1000);
        wr(6'h08, 32'hA0);
        t0 = cyc;
        adv_rd(6'h04, 500, d);  check("R4 count after 500", d, 500);
        adv_rd(6'h10, 998, d);  check("R5 raw before zero", d, 0);
        adv_rd(6'h04, 1000, d); check("R5 count at zero", d, 0);
        check("R11 irq0 at zero", {30'd0, irq_any, irq[0]}, 3);
        adv_rd(6'h04, 1002, d); check("R6 16-bit wrap", d, 32'hFFFE);
        adv_rd(6'h10, 1004, d); check("R5 raw held", d, 1);
        adv_rd(6'h14, 1006, d); check("R11 gated flag", d, 1);
        wr(6'h0C, 32'h0);
        rd(6'h10, d); check("R10 clear with zero data", d, 0);
        check("R10 irq dropped", {30'd0, irq_any, irq[0]}, 0);
        wr(6'h08, 32'h0);
        rd(6'h04, held);
        repeat (20) @(negedge clk);
        rd(6'h04, d); check("R13 stopped count holds", d, held);
    endtask

    task automatic t_periodic_256;
        logic [31:0] d, ch1_before;
        rd(6'h04, ch1_before);
        wr(6'h20, 20);
        wr(6'h28, 32'hE8);
        t0 = cyc;
        adv_rd(6'h24, 2559, d); check("R3 divide-256 just before tick", d, 11);
        adv_rd(6'h24, 2562, d); check("R3 divide-256 after tick", d, 10);
        adv_rd(6'h04, 2564, d); check("R14 ch1 unaffected", d, ch1_before);
        adv_rd(6'h30, 5118, d); check("R5 ch2 raw before zero", d, 0);
        adv_rd(6'h24, 5120, d); check("R5 ch2 count at zero", d, 0);
        check("R11 irq1 and combined", {29'd0, irq_any, irq}, 3'b110);
        adv_rd(6'h24, 5376, d); check("R7 periodic reload", d, 20);
        adv_rd(6'h24, 5378, d); check("R3 no tick mid-period", d, 20);
        wr(6'h2C, 32'hDEAD);
        rd(6'h30, d); check("R10 ch2 clear any data", d, 0);
        check("R11 combined low", {31'd0, irq_any}, 0);
        wr(6'h28, 32'h0);
    endtask

    task automatic t_oneshot_16;
        logic [31:0] d;
        wr(6'h00, 5);
        wr(6'h08, 32'h85);
        t0 = cyc;
        adv_rd(6'h04, 79, d); check("R3 divide-16 before tick", d, 1);
        adv_rd(6'h04, 81, d); check("R8 one-shot at zero", d, 0);
        adv_rd(6'h10, 83, d); check("R5 one-shot raw", d, 1);
        adv_rd(6'h14, 85, d); check("R11 gated off without enable", d, 0);
        check("R11 irq0 off without enable", {31'd0, irq[0]}, 0);
        adv_rd(6'h04, 200, d); check("R8 parked at zero", d, 0);
        wr(6'h18, 9);
        rd(6'h00, d); check("R9 start offset shows reload", d, 9);
        wr(6'h00, 3);
        t0 = cyc;
        adv_rd(6'h04, 15, d); check("R4 load restarts divider phase", d, 3);
        adv_rd(6'h04, 17, d); check("R4 first tick after load", d, 2);
        wr(6'h08, 32'hC1);
        wr(6'h00, 4);
        t0 = cyc;
        adv_rd(6'h04, 10, d); check("R8 one-shot overrides periodic", d, 0);
        wr(6'h0C, 32'h1);
        wr(6'h08, 32'h0);
    endtask

    task automatic t_reload_only;
        logic [31:0] d;
        wr(6'h20, 10);
        wr(6'h28, 32'hC0);
        t0 = cyc;
        adv_rd(6'h24, 4, d);  check("R4 ch2 count", d, 6);
        wr(6'h38, 3);
        adv_rd(6'h24, 9, d);  check("R9 reload-only leaves count", d, 1);
        adv_rd(6'h24, 11, d); check("R9 new reload used", d, 3);
        adv_rd(6'h30, 13, d); check("R5 ch2 raw", d, 1);
        adv_rd(6'h34, 15, d); check("R11 ch2 gated off", d, 0);
        check("R11 irq1 off", {31'd0, irq[1]}, 0);
        adv_rd(6'h24, 17, d); check("R7 second period", d, 1);
        wr(6'h28, 32'h0);
        wr(6'h2C, 32'h0);
    endtask

    task automatic t_width;
        logic [31:0] d;
        wr(6'h00, 32'h12345);
        rd(6'h04, d); check("R12 16-bit upper bits zero", d, 32'h2345);
        wr(6'h08, 32'h82);
        t0 = cyc;
        adv_rd(6'h04, 2, d); check("R12 32-bit count", d, 32'h12343);
        wr(6'h00, 32'h10000);
        t0 = cyc;
        adv_rd(6'h04, 2, d); check("R12 borrow across bit 16", d, 32'hFFFE);
        wr(6'h00, 1);
        t0 = cyc;
        adv_rd(6'h04, 2, d); check("R6 32-bit wrap", d, 32'hFFFFFFFF);
        wr(6'h08, 32'h0);
        wr(6'h0C, 32'h0);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_freerun();
        t_periodic_256();
        t_oneshot_16();
        t_reload_only();
        t_width();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule